// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is one DMA channel engine. Software writes a source address, a destination address, a link pointer and a control word, then sets the enable bit. The engine moves 32-bit words one at a time. Each word is read from the source into a one-word holding buffer and then written to the destination. It works over a single-beat bus master port. A priority grant from an external channel arbiter and a bus grant from the interconnect gate every beat.

The end of a transfer is decided in one of two ways. In the default mode the engine's own word count reaches zero. In the other mode the source peripheral flags its last word. At the end, the engine pulses an acknowledge to the source peripheral and sets a sticky terminal-count flag, which can be masked. If the link pointer is nonzero, it then fetches a four-word descriptor from memory and starts the next transfer without software. A bus error on any beat sets a sticky error flag and stops the channel.

Top module: `dma_chan`

## Requirements
- R1: Register writes use `reg_addr_i`: 0 source, 1 destination, 2 link, 3 control, 4 enable (bit 0 = 1 starts the channel), 5 status clear. After reset `busy_o`, `irq_tc_o`, `irq_err_o` and `bus_req_o` are 0, and no bus beat is requested before the channel is enabled.
- R2: A source read beat completes only in a cycle where `src_req_i`, `prio_gnt_i`, `bus_gnt_i` and `bus_ready_i` are all high. If any of them is held low, no read takes place.
- R3: A beat that completes with `bus_err_i` high sets `irq_err_o`, drops `busy_o` on the next cycle and requests no further beats. The failing write does not update memory.
- R4: In count mode (control bit 14 = 0), control bits [11:0] hold the word count. The count drops by one per destination write, and the transfer ends when it reaches zero. A count of 0 ends the transfer with no data beats.
- R5: In peripheral-flow mode (control bit 14 = 1), the count is ignored. The transfer ends after the destination write of the word whose read completed with `src_last_i` high.
- R6: At the end of each transfer, `src_ack_o` is high for exactly one cycle. No source reads take place from that point until the next transfer starts.
- R7: The end of a transfer sets the sticky `irq_tc_o`, unless control bit 15 is set. When bit 15 is set, `irq_tc_o` stays 0.
- R8: If the link register is nonzero at the end of a transfer, the engine reads four words at link, link+4, link+8 and link+12 into source, destination, link and control, and then transfers again. If the link is zero, the channel goes idle.
- R9: A word that has been read is held until `dst_req_i` is high. The destination write then carries that word.
- R10: Control bit 12 set makes the source address advance by 4 per read, and control bit 13 set does the same for the destination per write. When a bit is clear, that address stays fixed.
- R11: Writing 1 to bit 0 or bit 1 at address 5 clears `irq_tc_o` or `irq_err_o` respectively. Both flags hold until they are cleared.
- R12: While `busy_o` is high, writes to addresses 0 to 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| src_req_i | input | 1 | Source peripheral request |
| src_last_i | input | 1 | Source flags last word (peripheral-flow mode) |
| src_ack_o | output | 1 | End-of-transfer acknowledge to source |
| dst_req_i | input | 1 | Destination ready for a word |
| prio_gnt_i | input | 1 | Channel has highest pending priority |
| bus_gnt_i | input | 1 | Bus ownership grant |
| bus_ready_i | input | 1 | Beat completes this cycle |
| bus_err_i | input | 1 | Beat completes with error |
| bus_rdata_i | input | 32 | Read data |
| bus_req_o | output | 1 | Beat request |
| bus_we_o | output | 1 | Beat is a write |
| bus_addr_o | output | 32 | Beat address |
| bus_wdata_o | output | 32 | Write data |
| busy_o | output | 1 | Channel enabled and active |
| irq_tc_o | output | 1 | Sticky terminal-count flag |
| irq_err_o | output | 1 | Sticky error flag |

## Verification
A wrong count or a wrong address step shows up within one transfer, as missing or extra words, or words landing in the wrong destination slots. A fault in the end-of-transfer decision shows up as a wrong number of `src_ack_o` pulses, or as a transfer that runs past its end and is caught by the idle timeout. A bad descriptor fetch order shows up in the second transfer of a chain: its data lands at an unexpected address. A lost error or gating condition shows up within a few cycles as a beat that should not have happened, or as `busy_o` staying high.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WR, ST_DONE, ST_LD} st_e;
  localparam logic [2:0] A_SRC  = 3'd0;
  localparam logic [2:0] A_DST  = 3'd1;
  localparam logic [2:0] A_LINK = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_EN   = 3'd4;
  localparam logic [2:0] A_CLR  = 3'd5;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW    = 32,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [1:0]       sw_sel_i,
  input  logic [31:0]      sw_data_i,
  input  logic             ld_we_i,
  input  logic [1:0]       ld_sel_i,
  input  logic [31:0]      ld_data_i,
  input  logic             rd_step_i,
  input  logic             wr_step_i,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [AW-1:0]    link_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pflow_o,
  output logic             tc_mask_o
);
  localparam int INC_S = CNT_W;
  localparam int INC_D = CNT_W + 1;
  localparam int PFLOW = CNT_W + 2;
  localparam int MASK  = CNT_W + 3;
  localparam int CW    = CNT_W + 4;

  logic [AW-1:0] src_q, dst_q, link_q;
  logic [CW-1:0] ctrl_q;
  logic          we;
  logic [1:0]    sel;
  logic [31:0]   wd;

  assign we  = sw_we_i | ld_we_i;
  assign sel = sw_we_i ? sw_sel_i  : ld_sel_i;
  assign wd  = sw_we_i ? sw_data_i : ld_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      link_q <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      unique case (sel)
        2'd0: src_q  <= AW'(wd);
        2'd1: dst_q  <= AW'(wd);
        2'd2: link_q <= AW'(wd);
        default: ctrl_q <= wd[CW-1:0];
      endcase
    end else begin
      if (rd_step_i && ctrl_q[INC_S]) src_q <= src_q + AW'(4);
      if (wr_step_i) begin
        if (ctrl_q[INC_D]) dst_q <= dst_q + AW'(4);
        if (!ctrl_q[PFLOW]) ctrl_q[CNT_W-1:0] <= ctrl_q[CNT_W-1:0] - 1'b1;
      end
    end
  end

  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign link_o    = link_q;
  assign cnt_o     = ctrl_q[CNT_W-1:0];
  assign pflow_o   = ctrl_q[PFLOW];
  assign tc_mask_o = ctrl_q[MASK];

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_step_i && !we && !ctrl_q[PFLOW]) |=> (cnt_o == $past(cnt_o) - 1'b1));
  p_src_fixed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_step_i && !we && !ctrl_q[INC_S]) |=> $stable(src_o));
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_tc_i,
  input  logic       set_err_i,
  input  logic [1:0] clr_i,
  output logic       tc_o,
  output logic       err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      if (set_tc_i)      tc_o <= 1'b1;
      else if (clr_i[0]) tc_o <= 1'b0;
      if (set_err_i)     err_o <= 1'b1;
      else if (clr_i[1]) err_o <= 1'b0;
    end
  end

  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i[1]) |=> err_o);
  p_tc_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !clr_i[0]) |=> tc_o);
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [AW-1:0]    link_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pflow_i,
  input  logic             src_req_i,
  input  logic             src_last_i,
  input  logic             dst_req_i,
  input  logic             prio_gnt_i,
  input  logic             bus_gnt_i,
  input  logic             bus_ready_i,
  input  logic             bus_err_i,
  input  logic [31:0]      bus_rdata_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [31:0]      bus_wdata_o,
  output logic             rd_step_o,
  output logic             wr_step_o,
  output logic             ld_we_o,
  output logic [1:0]       ld_sel_o,
  output logic [31:0]      ld_data_o,
  output logic             done_o,
  output logic             err_o,
  output logic             src_ack_o,
  output logic             busy_o
);
  localparam logic [1:0] LAST_IDX = 2'(DESC_WORDS - 1);

  st_e           st_q;
  logic [31:0]   hold_q;
  logic          last_q;
  logic [AW-1:0] fa_q;
  logic [1:0]    idx_q;
  logic          beat, ok, cnt_zero;

  assign cnt_zero = (cnt_i == '0);

  always_comb begin
    bus_req_o  = 1'b0;
    bus_we_o   = 1'b0;
    bus_addr_o = src_i;
    unique case (st_q)
      ST_RD: bus_req_o = src_req_i & prio_gnt_i & (pflow_i | ~cnt_zero);
      ST_WR: begin
        bus_req_o  = dst_req_i & prio_gnt_i;
        bus_we_o   = 1'b1;
        bus_addr_o = dst_i;
      end
      ST_LD: begin
        bus_req_o  = prio_gnt_i;
        bus_addr_o = fa_q;
      end
      default: ;
    endcase
  end

  assign beat        = bus_req_o & bus_gnt_i & bus_ready_i;
  assign ok          = beat & ~bus_err_i;
  assign err_o       = beat & bus_err_i;
  assign rd_step_o   = ok & (st_q == ST_RD);
  assign wr_step_o   = ok & (st_q == ST_WR);
  assign ld_we_o     = ok & (st_q == ST_LD);
  assign ld_sel_o    = idx_q;
  assign ld_data_o   = bus_rdata_i;
  assign bus_wdata_o = hold_q;
  assign done_o      = (st_q == ST_DONE);
  assign src_ack_o   = (st_q == ST_DONE);
  assign busy_o      = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
      last_q <= 1'b0;
      fa_q   <= '0;
      idx_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_RD;
        ST_RD: begin
          if (!pflow_i && cnt_zero) st_q <= ST_DONE;
          else if (err_o) st_q <= ST_IDLE;
          else if (ok) begin
            hold_q <= bus_rdata_i;
            last_q <= src_last_i;
            st_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (err_o) st_q <= ST_IDLE;
          else if (ok) st_q <= (pflow_i ? last_q : (cnt_i == CNT_W'(1))) ? ST_DONE : ST_RD;
        end
        ST_DONE: begin
          if (link_i != '0) begin
            fa_q  <= link_i;
            idx_q <= '0;
            st_q  <= ST_LD;
          end else st_q <= ST_IDLE;
        end
        ST_LD: begin
          if (err_o) st_q <= ST_IDLE;
          else if (ok) begin
            fa_q  <= fa_q + AW'(4);
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) st_q <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !bus_req_o);
  p_rd_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_step_o |-> (src_req_i && prio_gnt_i && bus_gnt_i && bus_ready_i));
  p_err_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !busy_o);
  p_ack_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ack_o |=> !src_ack_o);
  p_wr_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR && !beat) |=> (st_q == ST_WR && $stable(bus_wdata_o)));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          src_req_i,
  input  logic          src_last_i,
  output logic          src_ack_o,
  input  logic          dst_req_i,
  input  logic          prio_gnt_i,
  input  logic          bus_gnt_i,
  input  logic          bus_ready_i,
  input  logic          bus_err_i,
  input  logic [31:0]   bus_rdata_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  output logic          busy_o,
  output logic          irq_tc_o,
  output logic          irq_err_o
);
  logic [AW-1:0]    src, dst, link;
  logic [CNT_W-1:0] cnt;
  logic             pflow, tc_mask;
  logic             rd_step, wr_step, ld_we, done, err, start, sw_we;
  logic [1:0]       ld_sel, clr;
  logic [31:0]      ld_data;

  assign sw_we = reg_we_i & ~busy_o & (reg_addr_i <= A_CTRL);
  assign start = reg_we_i & ~busy_o & (reg_addr_i == A_EN) & reg_wdata_i[0];
  assign clr   = (reg_we_i && reg_addr_i == A_CLR) ? reg_wdata_i[1:0] : 2'b00;

  dma_chan_regs #(.AW(AW), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni,
    .sw_we_i(sw_we), .sw_sel_i(reg_addr_i[1:0]), .sw_data_i(reg_wdata_i),
    .ld_we_i(ld_we), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
    .rd_step_i(rd_step), .wr_step_i(wr_step),
    .src_o(src), .dst_o(dst), .link_o(link), .cnt_o(cnt),
    .pflow_o(pflow), .tc_mask_o(tc_mask)
  );

  dma_chan_fsm #(.AW(AW), .CNT_W(CNT_W)) i_fsm (
    .clk_i, .rst_ni, .start_i(start),
    .src_i(src), .dst_i(dst), .link_i(link), .cnt_i(cnt), .pflow_i(pflow),
    .src_req_i, .src_last_i, .dst_req_i, .prio_gnt_i, .bus_gnt_i,
    .bus_ready_i, .bus_err_i, .bus_rdata_i,
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .rd_step_o(rd_step), .wr_step_o(wr_step),
    .ld_we_o(ld_we), .ld_sel_o(ld_sel), .ld_data_o(ld_data),
    .done_o(done), .err_o(err), .src_ack_o, .busy_o
  );

  dma_chan_irq i_irq (
    .clk_i, .rst_ni,
    .set_tc_i(done & ~tc_mask), .set_err_i(err), .clr_i(clr),
    .tc_o(irq_tc_o), .err_o(irq_err_o)
  );

  p_busy_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_i && reg_addr_i == A_SRC && !ld_we) |=> $stable(src));
  p_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && tc_mask && !irq_tc_o) |=> !irq_tc_o);
endmodule

// File: tb/test_dma_chan.sv
module test_dma_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        src_req_i = 1'b1, dst_req_i = 1'b1, prio_gnt_i = 1'b1, bus_gnt_i = 1'b1;
  logic        src_last_i, src_ack_o, bus_ready_i, bus_err_i;
  logic [31:0] bus_rdata_i, bus_wdata_o, bus_addr_o;
  logic        bus_req_o, bus_we_o, busy_o, irq_tc_o, irq_err_o;

  int checks = 0, errors = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, ack_cnt = 0, rd_base = 0;
  logic        last_arm = 1'b0, stall = 1'b0, err_arm = 1'b0;
  logic [31:0] err_addr = '0;
  logic        pre_we = 1'b0;
  logic [7:0]  pre_idx = '0;
  logic [31:0] pre_dat = '0;
  logic [31:0] mem [256];
  bit          finished = 1'b0;

  always #5 clk_i = ~clk_i;

  assign bus_rdata_i = mem[bus_addr_o[9:2]];
  assign bus_ready_i = !stall || cyc[0];
  assign bus_err_i   = err_arm && bus_req_o && (bus_addr_o == err_addr);
  assign src_last_i  = last_arm && (rd_cnt - rd_base == 2);

  function automatic logic [31:0] iv(int i);
    return 32'hA500_0000 | 32'(i);
  endfunction

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (src_ack_o) ack_cnt <= ack_cnt + 1;
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem[i] <= iv(i);
    end else if (pre_we) mem[pre_idx] <= pre_dat;
    else if (bus_req_o && bus_gnt_i && bus_ready_i && !bus_err_i) begin
      if (bus_we_o) begin
        mem[bus_addr_o[9:2]] <= bus_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end else rd_cnt <= rd_cnt + 1;
    end
  end

  dma_chan i_dma_chan (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic poke(logic [7:0] idx, logic [31:0] d);
    @(negedge clk_i);
    pre_we = 1'b1; pre_idx = idx; pre_dat = d;
    @(negedge clk_i);
    pre_we = 1'b0;
  endtask

  task automatic prog(logic [31:0] s, logic [31:0] d, logic [31:0] l, logic [31:0] c);
    wr_reg(3'd0, s); wr_reg(3'd1, d); wr_reg(3'd2, l); wr_reg(3'd3, c);
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy_o && n < 3000) begin
      @(negedge clk_i);
      n++;
    end
    chk({req, " idle"}, 32'(busy_o), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 tc", 32'(irq_tc_o), 0);
    chk("R1 err", 32'(irq_err_o), 0);
    chk("R1 req", 32'(bus_req_o), 0);
  endtask

  task automatic t_m2m;
    int w0 = wr_cnt, a0 = ack_cnt;
    prog(32'h100, 32'h200, 0, 32'h3004);
    wr_reg(3'd4, 1);
    wait_idle("R4");
    chk("R4 writes", 32'(wr_cnt - w0), 4);
    for (int k = 0; k < 4; k++) chk("R10 data", mem[8'h80 + k], iv(8'h40 + k));
    chk("R6 ack", 32'(ack_cnt - a0), 1);
    chk("R7 tc", 32'(irq_tc_o), 1);
    wr_reg(3'd5, 32'h1);
    chk("R11 tc clr", 32'(irq_tc_o), 0);
  endtask

  task automatic t_fixed_src;
    prog(32'h108, 32'h210, 0, 32'h2003);
    wr_reg(3'd4, 1);
    wait_idle("R10");
    for (int k = 0; k < 3; k++) chk("R10 fixed src", mem[8'h84 + k], iv(8'h42));
    wr_reg(3'd5, 3);
  endtask

  task automatic t_zero;
    int w0 = wr_cnt, r0 = rd_cnt;
    prog(32'h100, 32'h220, 0, 32'h3000);
    wr_reg(3'd4, 1);
    wait_idle("R4");
    chk("R4 zero writes", 32'(wr_cnt - w0), 0);
    chk("R4 zero reads", 32'(rd_cnt - r0), 0);
    chk("R4 zero tc", 32'(irq_tc_o), 1);
    wr_reg(3'd5, 3);
  endtask

  task automatic t_mask;
    prog(32'h100, 32'h230, 0, 32'hB001);
    wr_reg(3'd4, 1);
    wait_idle("R7");
    chk("R7 masked data", mem[8'h8C], iv(8'h40));
    chk("R7 masked tc", 32'(irq_tc_o), 0);
  endtask

  task automatic t_gate;
    int r0 = rd_cnt, w0 = wr_cnt;
    src_req_i = 1'b0;
    prog(32'h100, 32'h238, 0, 32'h3001);
    wr_reg(3'd4, 1);
    repeat (8) @(negedge clk_i);
    chk("R2 no src_req", 32'(rd_cnt - r0), 0);
    src_req_i = 1'b1; prio_gnt_i = 1'b0;
    repeat (8) @(negedge clk_i);
    chk("R2 no prio", 32'(rd_cnt - r0), 0);
    prio_gnt_i = 1'b1; bus_gnt_i = 1'b0;
    repeat (8) @(negedge clk_i);
    chk("R2 no gnt", 32'(rd_cnt - r0), 0);
    chk("R2 still busy", 32'(busy_o), 1);
    bus_gnt_i = 1'b1;
    wait_idle("R2");
    chk("R2 done", 32'(wr_cnt - w0), 1);
    wr_reg(3'd5, 3);
  endtask

  task automatic t_dstwait;
    int r0 = rd_cnt, w0 = wr_cnt;
    dst_req_i = 1'b0;
    prog(32'h104, 32'h23C, 0, 32'h3001);
    wr_reg(3'd4, 1);
    repeat (10) @(negedge clk_i);
    chk("R9 read done", 32'(rd_cnt - r0), 1);
    chk("R9 write held", 32'(wr_cnt - w0), 0);
    dst_req_i = 1'b1;
    wait_idle("R9");
    chk("R9 data", mem[8'h8F], iv(8'h41));
    wr_reg(3'd5, 3);
  endtask

  task automatic t_pflow;
    int w0 = wr_cnt, a0 = ack_cnt;
    rd_base = rd_cnt;
    last_arm = 1'b1;
    prog(32'h110, 32'h250, 0, 32'h7001);
    wr_reg(3'd4, 1);
    wait_idle("R5");
    last_arm = 1'b0;
    chk("R5 writes", 32'(wr_cnt - w0), 3);
    for (int k = 0; k < 3; k++) chk("R5 data", mem[8'h94 + k], iv(8'h44 + k));
    chk("R6 ack pflow", 32'(ack_cnt - a0), 1);
    wr_reg(3'd5, 3);
  endtask

  task automatic t_chain;
    int w0 = wr_cnt, a0 = ack_cnt;
    poke(8'hC0, 32'h140); poke(8'hC1, 32'h280); poke(8'hC2, 32'h0); poke(8'hC3, 32'h3002);
    stall = 1'b1;
    prog(32'h120, 32'h240, 32'h300, 32'h3002);
    wr_reg(3'd4, 1);
    wait_idle("R8");
    stall = 1'b0;
    chk("R8 writes", 32'(wr_cnt - w0), 4);
    chk("R8 first0", mem[8'h90], iv(8'h48));
    chk("R8 first1", mem[8'h91], iv(8'h49));
    chk("R8 second0", mem[8'hA0], iv(8'h50));
    chk("R8 second1", mem[8'hA1], iv(8'h51));
    chk("R6 ack chain", 32'(ack_cnt - a0), 2);
    wr_reg(3'd5, 3);
  endtask

  task automatic t_err;
    int w0 = wr_cnt;
    int q = 0;
    err_arm = 1'b1; err_addr = 32'h2C4;
    prog(32'h100, 32'h2C0, 0, 32'h3004);
    wr_reg(3'd4, 1);
    wait_idle("R3");
    chk("R3 err", 32'(irq_err_o), 1);
    chk("R3 writes", 32'(wr_cnt - w0), 1);
    chk("R3 bad slot", mem[8'hB1], iv(8'hB1));
    chk("R3 no tc", 32'(irq_tc_o), 0);
    repeat (5) begin
      @(negedge clk_i);
      if (bus_req_o) q++;
    end
    chk("R3 quiet", 32'(q), 0);
    err_arm = 1'b0;
    wr_reg(3'd5, 32'h2);
    chk("R11 err clr", 32'(irq_err_o), 0);
  endtask

  task automatic t_busy_ignore;
    int w0 = wr_cnt;
    src_req_i = 1'b0;
    prog(32'h100, 32'h2E0, 0, 32'h3001);
    wr_reg(3'd4, 1);
    wr_reg(3'd0, 32'h180);
    wr_reg(3'd3, 32'h3005);
    wr_reg(3'd4, 1);
    src_req_i = 1'b1;
    wait_idle("R12");
    chk("R12 src kept", mem[8'hB8], iv(8'h40));
    chk("R12 count kept", 32'(wr_cnt - w0), 1);
    wr_reg(3'd5, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_m2m();
    t_fixed_src();
    t_zero();
    t_mask();
    t_gate();
    t_dstwait();
    t_pflow();
    t_chain();
    t_err();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule